// File: doc/BRIEF.md
# Column-Scanned Dot Matrix Scan Controller

This block refreshes an emissive dot matrix of 8 row lines by 64 column lines. One column is selected at a time, and a 6-bit column index is decoded to a one-hot select. While a column is selected, any subset of the eight row lines can be on. Each pixel holds a 3-bit intensity code. Brightness comes from how long the row line stays on inside the column slot. Code 0 keeps the pixel dark, and code 7 keeps it lit for the whole drive part of the slot.

Image data enters a back buffer one column (eight codes) per write. A commit request copies the back buffer into the displayed buffer, but only at the next frame boundary, so a frame never mixes two images. The back buffer keeps its contents after the copy, so an update can change only the columns that differ. A horizontal scroll offset remaps displayed column c to stored column (c + offset) mod 64. The offset is also taken only at a frame boundary. Stepping the offset by one per frame moves a stored message across the display.

Slot timing comes from the system clock. Every slot has one guard clock followed by seven intensity phases, and each phase lasts `phase_len_m1 + 1` clocks. The nominal figures are a slot of about 365 us and a frame of about 23.4 ms, which keeps the refresh rate above 40 Hz. Software reaches these figures by choosing `phase_len_m1` for the system clock in use. The sequencer has two states. ST_GUARD lasts one clock and always moves to ST_DRIVE (transition "open"). ST_DRIVE stays in ST_DRIVE while phases remain (transition "step"). After the last clock of phase 6, ST_DRIVE returns to ST_GUARD and moves to the next column (transition "advance"). When the column being left is 63, "advance" goes to column 0 instead (transition "wrap").

Top module: `dotmatrix_scan_ctrl`

## Requirements
- R1: While reset is held, `col_idx` is 0, `col_sel` is 1 (bit 0 only) and `row_en` is 0. The displayed buffer and the back buffer both reset to all-zero codes, and the scroll offset resets to 0.
- R2: `col_sel` always has exactly one bit set, and that bit is the one at position `col_idx`.
- R3: `col_idx` only ever increases by one or wraps from 63 to 0. Every column slot lasts 1 + 7 x (`phase_len_m1` + 1) clocks.
- R4: On the first clock of every column slot (the guard clock), `row_en` is all zero.
- R5: Within a slot, row r is on for code x (`phase_len_m1` + 1) clocks. Here code is the 3-bit field at bits [3r+2:3r] of the column's stored word, and a row is on during phase p when code > p.
- R6: Code 7 on every row turns all eight rows on at the same time for the whole drive part of the slot.
- R7: `frame_start` is high for exactly one clock per frame, during the guard clock of column 0. Consecutive pulses are 64 slots apart.
- R8: A write without a commit does not change the display. After a commit, the displayed image stays unchanged for the rest of the current frame and shows the new data from the next frame on.
- R9: Displayed column c shows stored column (c + offset) mod 64. A new offset takes effect at the next frame boundary and not before.
- R10: The back buffer keeps its contents across a copy, so columns written before an earlier commit stay visible after a later commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_len_m1 | input | 16 | Clocks per intensity phase minus one |
| scroll_off | input | 6 | Horizontal scroll offset, taken at frame boundary |
| wr_en | input | 1 | Write one column into the back buffer |
| wr_col | input | 6 | Column written |
| wr_codes | input | 24 | Eight 3-bit codes; row r at bits [3r+2:3r] |
| commit | input | 1 | Request copy of back buffer at next frame boundary |
| col_idx | output | 6 | Active column index |
| col_sel | output | 64 | One-hot column select |
| row_en | output | 8 | Row line enables for the active column |
| frame_start | output | 1 | High during the guard clock of column 0 |

## Verification
An off-by-one in the phase counter shows up as a wrong slot length within the first slot after reset, and as row on-times that miss code x (phase length) in any slot that is measured. If the pending-commit flag or the scroll latch is handled wrongly, the image changes in the middle of a frame, or never changes. This is visible one frame after the commit or offset change, when the same column is observed in two consecutive frames. A corrupt column counter breaks the one-hot relation with `col_sel`, or the 64-slot spacing of `frame_start`, by the next column change.

// File: rtl/dm_pkg.sv
package dm_pkg;
    typedef enum logic [1:0] {
        ST_GUARD = 2'd0,
        ST_DRIVE = 2'd1
    } scan_state_t;
endpackage

// File: rtl/dm_col_decode.sv
module dm_col_decode #(
    parameter int NUM_COLS = 64,
    parameter int COL_W    = $clog2(NUM_COLS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [COL_W-1:0]    col_idx,
    output logic [NUM_COLS-1:0] col_sel
);
    for (genvar i = 0; i < NUM_COLS; i++) begin : g_sel
        assign col_sel[i] = (col_idx == COL_W'(i));
    end

    // R2: exactly one select line, matching the index
    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        ($countones(col_sel) == 1) && col_sel[col_idx]);
endmodule

// File: rtl/dm_slot_seq.sv
module dm_slot_seq
    import dm_pkg::*;
#(
    parameter int NUM_COLS = 64,
    parameter int COL_W    = $clog2(NUM_COLS),
    parameter int CODE_W   = 3,
    parameter int PRESC_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PRESC_W-1:0] phase_len_m1,
    output logic [COL_W-1:0]   col_idx,
    output logic [CODE_W-1:0]  phase,
    output logic               drive_on,
    output logic               frame_start,
    output logic               swap_now
);
    localparam int LAST_PH = (1 << CODE_W) - 2;
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(NUM_COLS - 1);

    scan_state_t        state_q;
    logic [PRESC_W-1:0] cnt_q;
    logic               ph_done;
    logic               slot_done;

    assign ph_done   = (cnt_q >= phase_len_m1);
    assign slot_done = ph_done && (phase == CODE_W'(LAST_PH));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_GUARD;
            col_idx <= '0;
            phase   <= '0;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_GUARD: begin
                    state_q <= ST_DRIVE;
                    phase   <= '0;
                    cnt_q   <= '0;
                end
                ST_DRIVE: begin
                    if (slot_done) begin
                        state_q <= ST_GUARD;
                        col_idx <= (col_idx == LAST_COL) ? '0 : col_idx + 1'b1;
                        phase   <= '0;
                        cnt_q   <= '0;
                    end else if (ph_done) begin
                        phase <= phase + 1'b1;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ST_GUARD;
            endcase
        end
    end

    // outputs
    always_comb begin
        drive_on    = 1'b0;
        frame_start = 1'b0;
        swap_now    = 1'b0;
        unique case (state_q)
            ST_GUARD: frame_start = (col_idx == '0);
            ST_DRIVE: begin
                drive_on = 1'b1;
                swap_now = slot_done && (col_idx == LAST_COL);
            end
            default: ;
        endcase
    end

    // R3: column index steps by one or wraps
    assert_col_step_R3: assert property (@(posedge clk) disable iff (rst)
        (col_idx != $past(col_idx)) |->
        (col_idx == (($past(col_idx) == LAST_COL) ? '0 : $past(col_idx) + 1'b1)));
endmodule

// File: rtl/dm_frame_store.sv
module dm_frame_store #(
    parameter int NUM_COLS = 64,
    parameter int COL_W    = $clog2(NUM_COLS),
    parameter int ROW_BITS = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [COL_W-1:0]    wr_col,
    input  logic [ROW_BITS-1:0] wr_codes,
    input  logic                commit,
    input  logic [COL_W-1:0]    scroll_off,
    input  logic                swap_now,
    input  logic [COL_W-1:0]    col_idx,
    output logic [ROW_BITS-1:0] rd_codes
);
    logic [ROW_BITS-1:0] back_q  [NUM_COLS];
    logic [ROW_BITS-1:0] front_q [NUM_COLS];
    logic                pending_q;
    logic [COL_W-1:0]    scroll_q;
    logic [COL_W:0]      sum;
    logic [COL_W-1:0]    rd_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_COLS; i++) begin
                back_q[i]  <= '0;
                front_q[i] <= '0;
            end
            pending_q <= 1'b0;
            scroll_q  <= '0;
        end else begin
            if (wr_en) back_q[wr_col] <= wr_codes;
            if (swap_now) begin
                scroll_q <= scroll_off;
                if (pending_q) front_q <= back_q;
            end
            pending_q <= (pending_q && !swap_now) || commit;
        end
    end

    assign sum      = {1'b0, col_idx} + {1'b0, scroll_q};
    assign rd_idx   = (sum >= (COL_W+1)'(NUM_COLS)) ? COL_W'(sum - (COL_W+1)'(NUM_COLS))
                                                    : COL_W'(sum);
    assign rd_codes = front_q[rd_idx];

    // R8/R9: displayed data only moves at a frame boundary
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(swap_now) && $stable(col_idx)) |-> $stable(rd_codes));
    assert_scroll_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !swap_now |=> $stable(scroll_q));
endmodule

// File: rtl/dotmatrix_scan_ctrl.sv
module dotmatrix_scan_ctrl #(
    parameter int NUM_COLS = 64,
    parameter int NUM_ROWS = 8,
    parameter int CODE_W   = 3,
    parameter int PRESC_W  = 16,
    localparam int COL_W    = $clog2(NUM_COLS),
    localparam int ROW_BITS = NUM_ROWS * CODE_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PRESC_W-1:0]  phase_len_m1,
    input  logic [COL_W-1:0]    scroll_off,
    input  logic                wr_en,
    input  logic [COL_W-1:0]    wr_col,
    input  logic [ROW_BITS-1:0] wr_codes,
    input  logic                commit,
    output logic [COL_W-1:0]    col_idx,
    output logic [NUM_COLS-1:0] col_sel,
    output logic [NUM_ROWS-1:0] row_en,
    output logic                frame_start
);
    logic [CODE_W-1:0]   phase;
    logic                drive_on;
    logic                swap_now;
    logic [ROW_BITS-1:0] pix_codes;

    dm_slot_seq #(.NUM_COLS(NUM_COLS), .COL_W(COL_W), .CODE_W(CODE_W), .PRESC_W(PRESC_W)) u_seq (
        .clk(clk), .rst(rst), .phase_len_m1(phase_len_m1),
        .col_idx(col_idx), .phase(phase), .drive_on(drive_on),
        .frame_start(frame_start), .swap_now(swap_now)
    );

    dm_frame_store #(.NUM_COLS(NUM_COLS), .COL_W(COL_W), .ROW_BITS(ROW_BITS)) u_store (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_col(wr_col), .wr_codes(wr_codes),
        .commit(commit), .scroll_off(scroll_off), .swap_now(swap_now),
        .col_idx(col_idx), .rd_codes(pix_codes)
    );

    dm_col_decode #(.NUM_COLS(NUM_COLS), .COL_W(COL_W)) u_dec (
        .clk(clk), .rst(rst), .col_idx(col_idx), .col_sel(col_sel)
    );

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        assign row_en[r] = drive_on && (pix_codes[r*CODE_W +: CODE_W] > phase);
    end

    // R4: rows dark on the clock a new column begins
    assert_guard_R4: assert property (@(posedge clk) disable iff (rst)
        (col_idx != $past(col_idx)) |-> (row_en == '0));
    // R7: frame strobe only on column 0 with rows dark
    assert_frame_R7: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> ((col_idx == '0) && (row_en == '0)));
endmodule

// File: tb/test_dotmatrix_scan_ctrl.sv
module test_dotmatrix_scan_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] phase_len_m1 = '0;
    logic [5:0]  scroll_off = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_col = '0;
    logic [23:0] wr_codes = '0;
    logic        commit = 1'b0;
    logic [5:0]  col_idx;
    logic [63:0] col_sel;
    logic [7:0]  row_en;
    logic        frame_start;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int obs_len;
    int obs_on [8];
    bit obs_guard;

    always #2 clk = ~clk;

    dotmatrix_scan_ctrl i_dotmatrix_scan_ctrl (
        .clk(clk), .rst(rst), .phase_len_m1(phase_len_m1), .scroll_off(scroll_off),
        .wr_en(wr_en), .wr_col(wr_col), .wr_codes(wr_codes), .commit(commit),
        .col_idx(col_idx), .col_sel(col_sel), .row_en(row_en), .frame_start(frame_start)
    );

    localparam int NV = 6;
    localparam logic [23:0] VEC_CODES [NV] = '{24'o77777777, 24'o76543210, 24'o01234567,
                                                24'o00000000, 24'o70707070, 24'o35353535};
    localparam int VEC_DIV [NV] = '{0, 0, 1, 2, 1, 0};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_col(input int col, input logic [23:0] codes);
        @(negedge clk);
        wr_en = 1'b1; wr_col = 6'(col); wr_codes = codes;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk);
        commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic wait_frame();
        @(negedge clk);
        while (!frame_start) @(negedge clk);
    endtask

    task automatic observe(input int col);
        @(negedge clk);
        while (col_idx == 6'(col)) @(negedge clk);
        while (col_idx != 6'(col)) @(negedge clk);
        obs_guard = (row_en == 8'h00);
        obs_len = 0;
        for (int r = 0; r < 8; r++) obs_on[r] = 0;
        while (col_idx == 6'(col)) begin
            obs_len++;
            for (int r = 0; r < 8; r++) if (row_en[r]) obs_on[r]++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_total++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        int prev;
        int steps_bad;
        int fcount;
        int flen;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(col_idx == 6'd0, "R1 col_idx", int'(col_idx), 0);
        check(col_sel == 64'd1, "R1 col_sel", int'(col_sel[31:0]), 1);
        check(row_en == 8'd0, "R1 row_en", int'(row_en), 0);
        rst = 1'b0;

        // R2/R3/R7: one frame sweep at phase length 1
        wait_frame();
        prev = int'(col_idx); steps_bad = 0; fcount = 0; flen = 0;
        do begin
            @(negedge clk);
            flen++;
            if (col_sel != (64'd1 << col_idx)) steps_bad++;
            if (int'(col_idx) != prev && int'(col_idx) != ((prev + 1) % 64)) steps_bad++;
            prev = int'(col_idx);
            if (frame_start) fcount++;
        end while (!frame_start);
        check(steps_bad == 0, "R2 R3 column order and select", steps_bad, 0);
        check(flen == 512, "R7 frame length", flen, 512);
        check(fcount == 1, "R7 one pulse per frame", fcount, 1);

        // R3/R4/R5/R6: vector table on column 10
        for (int i = 0; i < NV; i++) begin
            phase_len_m1 = 16'(VEC_DIV[i]);
            write_col(10, VEC_CODES[i]);
            do_commit();
            wait_frame();
            observe(10);
            check(obs_len == 1 + 7 * (VEC_DIV[i] + 1), "R3 slot length", obs_len,
                  1 + 7 * (VEC_DIV[i] + 1));
            check(obs_guard, "R4 guard clock dark", int'(obs_guard), 1);
            for (int r = 0; r < 8; r++) begin
                int code;
                code = int'(VEC_CODES[i][r*3 +: 3]);
                check(obs_on[r] == code * (VEC_DIV[i] + 1),
                      (code == 7) ? "R6 R5 row on-time" : "R5 row on-time",
                      obs_on[r], code * (VEC_DIV[i] + 1));
            end
        end
        phase_len_m1 = '0;

        // R8: write without commit is invisible; commit waits for boundary
        write_col(30, 24'o77777777);
        wait_frame(); wait_frame();
        observe(30);
        check(obs_on[0] == 0 && obs_on[7] == 0, "R8 no commit no change", obs_on[0], 0);
        wait_frame();
        commit = 1'b1; @(negedge clk); commit = 1'b0;
        observe(30);
        check(obs_on[3] == 0, "R8 current frame unchanged", obs_on[3], 0);
        observe(30);
        check(obs_on[3] == 7, "R8 next frame shows data", obs_on[3], 7);

        // R10: back buffer retained across copies
        write_col(20, 24'o00000007);
        do_commit(); wait_frame();
        write_col(21, 24'o00000070);
        do_commit(); wait_frame();
        observe(20);
        check(obs_on[0] == 7 && obs_on[1] == 0, "R10 earlier column kept", obs_on[0], 7);
        observe(21);
        check(obs_on[1] == 7, "R10 new column shown", obs_on[1], 7);

        // R9: scroll offset at frame boundary
        wait_frame();
        scroll_off = 6'd1;
        observe(20);
        check(obs_on[0] == 7 && obs_on[1] == 0, "R9 offset not yet applied", obs_on[0], 7);
        observe(20);
        check(obs_on[1] == 7 && obs_on[0] == 0, "R9 offset 1 applied", obs_on[1], 7);
        scroll_off = 6'd63;
        write_col(63, 24'o00000700);
        do_commit();
        wait_frame(); wait_frame();
        observe(0);
        check(obs_on[2] == 7, "R9 wrap col 0 shows stored 63", obs_on[2], 7);
        observe(21);
        check(obs_on[0] == 7 && obs_on[1] == 0, "R9 col 21 shows stored 20", obs_on[0], 7);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule